// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. The page tables it reads sit in ordinary memory. A request carries the virtual address and the current table root. The block first looks in a small fully associative cache of finished translations. On a hit it answers one cycle after it accepts the request, and it issues no memory traffic.

On a miss it reads two table entries over a word-read port, one after the other. The upper ten bits of the page number pick the entry in the first-level table. That entry names the page that holds the second-level table. The next ten bits pick the leaf entry there, and the leaf gives the physical page.

An entry whose resident bit is clear ends the walk with a page-fault response. A fault in the first level ends the walk before the second read is issued. Only good leaf translations go into the cache. A flush input empties the cache when software changes the root. The walker handles one translation at a time and raises `busy` until it delivers the response.

Top module: `ptw_unit`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_rd_valid` are all low.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. From the cycle after a missing request is accepted until its response cycle, `busy` is high, and `req_valid` has no effect in those cycles. In the response cycle, `busy` is low.
- R3: On a cache miss, `mem_rd_valid` pulses for exactly one cycle, in the cycle after acceptance. Its address is `root + 4*va[31:22]`.
- R4: A table entry is resident when bit 0 is 1. If the first-level entry is not resident, the response is a fault. A fault drives `rsp_fault` = 1 and `rsp_paddr` = 0. The walk issues no second read, and the response comes in the cycle after that memory response.
- R5: For a resident first-level entry E1, the second read goes out in the cycle after the first response. Its address is `{E1[31:12], va[21:12], 2'b00}`.
- R6: If the leaf entry has bit 0 clear, the response is a fault. This holds even when the leaf's page-number bits are nonzero.
- R7: For a resident leaf E2, `rsp_paddr` = `{E2[31:12], va[11:0]}` and `rsp_fault` = 0. `rsp_valid` is high for one cycle, the cycle after the second memory response.
- R8: A later request to a cached virtual page gets its response in the cycle after acceptance. The response keeps the new offset, and the block issues no memory read.
- R9: Faulting translations are not cached, so a repeated request to the same faulting page walks again.
- R10: A `flush` pulse invalidates every cached translation. A request accepted in the same cycle as `flush` is treated as a miss.
- R11: The cache holds `TLB_ENTRIES` translations and refills them in round-robin order starting at slot 0. After one more distinct page is filled, the page filled first misses, and the page filled second still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Base byte address of the first-level table |
| flush | input | 1 | Invalidate all cached translations |
| busy | output | 1 | Walk in progress; requests are not taken |
| mem_rd_valid | output | 1 | One-cycle word read request |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Translation response |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault |

## Verification
A walker stuck in the wrong state shows at once at the ports. `busy` stays high, a read pulse lasts too long, or a second read follows a non-resident first-level entry. Each of these appears within one cycle of the memory response that caused it.

Corrupt cache contents do not show until the same virtual page is requested again. At that point the hit returns a wrong page number in the very next cycle, with no memory read. A lost or stale cache entry shows the opposite way: a walk with two reads where the count of zero was expected.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int PN_W  = VA_W - OFF_W;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_L1_REQ,
        WK_L1_WAIT,
        WK_L2_REQ,
        WK_L2_WAIT
    } walk_st_e;
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
    import ptw_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_vpn,
    output logic            lk_hit,
    output logic [PN_W-1:0] lk_ppn,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][PN_W-1:0] vpn;
        logic [ENTRIES-1:0][PN_W-1:0] ppn;
        logic [PTR_W-1:0]             ptr;
    } tlb_s;

    tlb_s tlb_d, tlb_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tlb_q.vld[g] && (tlb_q.vpn[g] == lk_vpn);
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_ppn = lk_ppn | tlb_q.ppn[i];
        end
        lk_hit = (|match) && !flush;
    end

    always_comb begin
        tlb_d = tlb_q;
        if (flush) begin
            tlb_d.vld = '0;
        end else if (fill_en) begin
            tlb_d.vld[tlb_q.ptr] = 1'b1;
            tlb_d.vpn[tlb_q.ptr] = fill_vpn;
            tlb_d.ppn[tlb_q.ptr] = fill_ppn;
            tlb_d.ptr = (tlb_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : tlb_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tlb_q <= '0;
        else        tlb_q <= tlb_d;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_fire,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] req_root,
    input  logic            tlb_hit,
    input  logic [PN_W-1:0] tlb_ppn,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            busy,
    output logic            mem_rd_valid,
    output logic [VA_W-1:0] mem_rd_addr,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic            fill_en,
    output logic [PN_W-1:0] fill_vpn,
    output logic [PN_W-1:0] fill_ppn
);
    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] vaddr;
        logic [VA_W-1:0] addr;
        logic            rsp_v;
        logic [VA_W-1:0] paddr;
        logic            fault;
    } walk_s;

    walk_s w_d, w_q;
    logic  ent_ok;
    logic  unused_status;

    assign ent_ok        = mem_rsp_data[0];
    assign unused_status = ^mem_rsp_data[OFF_W-1:1];

    always_comb begin
        w_d       = w_q;
        w_d.rsp_v = 1'b0;
        unique case (w_q.st)
            WK_IDLE: begin
                if (req_fire) begin
                    w_d.vaddr = req_vaddr;
                    if (tlb_hit) begin
                        w_d.rsp_v = 1'b1;
                        w_d.fault = 1'b0;
                        w_d.paddr = {tlb_ppn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        w_d.st   = WK_L1_REQ;
                        w_d.addr = req_root
                                 + {{(VA_W-IDX_W-2){1'b0}}, req_vaddr[VA_W-1 -: IDX_W], 2'b00};
                    end
                end
            end
            WK_L1_REQ: w_d.st = WK_L1_WAIT;
            WK_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_ok) begin
                        w_d.st    = WK_IDLE;
                        w_d.rsp_v = 1'b1;
                        w_d.fault = 1'b1;
                        w_d.paddr = '0;
                    end else begin
                        w_d.st   = WK_L2_REQ;
                        w_d.addr = {mem_rsp_data[VA_W-1:OFF_W],
                                    w_q.vaddr[OFF_W +: IDX_W], 2'b00};
                    end
                end
            end
            WK_L2_REQ: w_d.st = WK_L2_WAIT;
            WK_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.st    = WK_IDLE;
                    w_d.rsp_v = 1'b1;
                    w_d.fault = !ent_ok;
                    w_d.paddr = ent_ok ? {mem_rsp_data[VA_W-1:OFF_W], w_q.vaddr[OFF_W-1:0]} : '0;
                end
            end
            default: w_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: WK_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign busy         = (w_q.st != WK_IDLE);
    assign mem_rd_valid = (w_q.st == WK_L1_REQ) || (w_q.st == WK_L2_REQ);
    assign mem_rd_addr  = w_q.addr;
    assign rsp_valid    = w_q.rsp_v;
    assign rsp_paddr    = w_q.paddr;
    assign rsp_fault    = w_q.fault;
    assign fill_en      = (w_q.st == WK_L2_WAIT) && mem_rsp_valid && ent_ok;
    assign fill_vpn     = w_q.vaddr[VA_W-1:OFF_W];
    assign fill_ppn     = mem_rsp_data[VA_W-1:OFF_W];
endmodule

// File: rtl/ptw_unit.sv
module ptw_unit
    import ptw_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_root,
    input  logic        flush,
    output logic        busy,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault
);
    logic            req_fire;
    logic            tlb_hit;
    logic [PN_W-1:0] tlb_ppn;
    logic            fill_en;
    logic [PN_W-1:0] fill_vpn;
    logic [PN_W-1:0] fill_ppn;

    assign req_fire = req_valid && !busy;

    ptw_tlb #(.ENTRIES(TLB_ENTRIES)) tlb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit   (tlb_hit),
        .lk_ppn   (tlb_ppn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn)
    );

    ptw_walker walk_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_fire      (req_fire),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .tlb_hit       (tlb_hit),
        .tlb_ppn       (tlb_ppn),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_ppn      (fill_ppn)
    );
endmodule

// File: rtl/ptw_unit_chk.sv
module ptw_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [31:0] req_root,
    input logic        flush,
    input logic        busy,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault
);
    logic [31:0] acc_va_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                 acc_va_q <= '0;
        else if (req_valid && !busy) acc_va_q <= req_vaddr;
    end

    // R2: no memory traffic and no response while a walk is absent / present
    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);
    p_rsp_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);
    // R3: read request is a single-cycle pulse at the first-level address
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);
    p_l1_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (!mem_rd_valid ||
            mem_rd_addr == $past(req_root) + {20'b0, $past(req_vaddr[31:22]), 2'b00}));
    // R4: a fault carries a zero address
    p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));
    // R7: the page offset passes through unchanged
    p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == acc_va_q[11:0]));
    // R10: a request accepted with flush always walks
    p_flush_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && flush) |=> (mem_rd_valid && !rsp_valid));
endmodule

bind ptw_unit ptw_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_root     (req_root),
    .flush        (flush),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault)
);

// File: tb/ptw_unit_tb_top.sv
module ptw_unit_tb_top;
    localparam int MEM_LAT = 2;
    localparam logic [31:0] ROOT_A = 32'h0001_0000;
    localparam logic [31:0] ROOT_B = 32'h0003_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        flush = 1'b0;
    logic        busy;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;

    int n_checks = 0;
    int n_errors = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [0:3];
    bit done = 0;

    always #10 clk = ~clk;

    ptw_unit #(.TLB_ENTRIES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_root(req_root), .flush(flush), .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [31:0] table_word(input logic [31:0] a);
        case (a)
            32'h0001_0004: return 32'h0002_0001;
            32'h0002_000C: return 32'h000A_B001;
            32'h0002_0014: return 32'h0007_7003;
            32'h0002_001C: return 32'h0009_9000;
            32'h0002_0024: return 32'h0001_2001;
            32'h0003_000C: return 32'h0004_0001;
            32'h0004_0008: return 32'hFFFF_F001;
            32'h0001_0FFC: return 32'h0005_0001;
            32'h0005_0FFC: return 32'h0000_0001;
            default:       return 32'h0000_0000;
        endcase
    endfunction

    // memory model: fixed latency, one response per read
    initial begin
        int cnt = 0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = table_word(a);
                end
            end
            if (mem_rd_valid) begin
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                a   = mem_rd_addr;
                cnt = MEM_LAT;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic do_req(input logic [31:0] va, input logic [31:0] root, input logic fl,
                          output logic [31:0] pa, output logic flt, output int lat);
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        flush     = fl;
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        pa  = rsp_paddr;
        flt = rsp_fault;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic        flt;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [31:0] a1;
        logic [31:0] a2;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{32'h0040_3ABC, ROOT_A, 1'b0, 32'h000A_BABC, 2'd2, 32'h0001_0004, 32'h0002_000C},
        '{32'h0040_3123, ROOT_A, 1'b0, 32'h000A_B123, 2'd0, 32'h0, 32'h0},
        '{32'h0080_0456, ROOT_A, 1'b1, 32'h0000_0000, 2'd1, 32'h0001_0008, 32'h0},
        '{32'h0080_0456, ROOT_A, 1'b1, 32'h0000_0000, 2'd1, 32'h0001_0008, 32'h0},
        '{32'h0040_7010, ROOT_A, 1'b1, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0002_001C},
        '{32'h0040_5123, ROOT_A, 1'b0, 32'h0007_7123, 2'd2, 32'h0001_0004, 32'h0002_0014},
        '{32'h00C0_2FFF, ROOT_B, 1'b0, 32'hFFFF_FFFF, 2'd2, 32'h0003_000C, 32'h0004_0008},
        '{32'hFFFF_F000, ROOT_A, 1'b0, 32'h0000_0000, 2'd2, 32'h0001_0FFC, 32'h0005_0FFC}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [31:0] pa;
        logic        flt;
        int          lat;

        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'b0, busy}, 32'd0);
        check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'b0, busy}, 32'd0);
        check("R1 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            do_req(VECS[i].va, VECS[i].root, 1'b0, pa, flt, lat);
            check($sformatf("R7 vec%0d paddr", i), pa, VECS[i].pa);
            check($sformatf("R4 R6 vec%0d fault", i), {31'b0, flt}, {31'b0, VECS[i].flt});
            check($sformatf("R8 R9 vec%0d reads", i), rd_cnt, {30'b0, VECS[i].nrd});
            check($sformatf("R7 R8 vec%0d latency", i), lat, 1 + 3 * VECS[i].nrd);
            if (VECS[i].nrd > 0) check($sformatf("R3 vec%0d L1 addr", i), rd_addr[0], VECS[i].a1);
            if (VECS[i].nrd > 1) check($sformatf("R5 vec%0d L2 addr", i), rd_addr[1], VECS[i].a2);
        end

        // R11 round-robin replacement: fifth page lands in slot 0
        do_req(32'h0040_9000, ROOT_A, 1'b0, pa, flt, lat);
        check("R11 new page paddr", pa, 32'h0001_2000);
        check("R11 new page walks", rd_cnt, 2);
        do_req(32'h0040_5000, ROOT_A, 1'b0, pa, flt, lat);
        check("R11 second-filled page still hits", rd_cnt, 0);
        check("R11 hit paddr", pa, 32'h0007_7000);
        do_req(32'h0040_3000, ROOT_A, 1'b0, pa, flt, lat);
        check("R11 first-filled page evicted", rd_cnt, 2);
        check("R11 refill paddr", pa, 32'h000A_B000);

        // R10 flush
        pulse_flush();
        do_req(32'h0040_3000, ROOT_A, 1'b0, pa, flt, lat);
        check("R10 flush forces walk", rd_cnt, 2);
        do_req(32'h0040_3000, ROOT_A, 1'b1, pa, flt, lat);
        check("R10 flush with request forces walk", rd_cnt, 2);
        check("R10 paddr after flushed walk", pa, 32'h000A_B000);
        do_req(32'h0040_3000, ROOT_A, 1'b0, pa, flt, lat);
        check("R10 refill then hit", rd_cnt, 0);

        // R2 requests while busy are ignored
        pulse_flush();
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1;
        req_vaddr = 32'h0040_5ABC;
        req_root  = ROOT_A;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            req_vaddr = 32'h0080_0456;
            check("R2 busy during walk", {31'b0, busy}, 32'd1);
        end
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check("R2 busy low at response", {31'b0, busy}, 32'd0);
        check("R2 first request answered", rsp_paddr, 32'h0007_7ABC);
        check("R2 no fault from ignored request", {31'b0, rsp_fault}, 32'd0);
        repeat (4) @(negedge clk);
        check("R2 ignored request made no reads", rd_cnt, 2);
        check("R2 no further response", {31'b0, rsp_valid}, 32'd0);

        finish_sim();
    end
endmodule